// File: doc/BRIEF.md
# Pin-Configured Divider and Phase-Frequency Detector Core

This block is the digital heart of a fixed-ratio frequency synthesizer. A reference signal is divided by two, and a feedback signal from the oscillator is divided by 8, 16, 32 or 64, depending on a two-bit ratio pin pair. A phase-frequency detector compares the rising edges of the two divided signals. It raises a pump-up request when the reference edge arrives first and a pump-down request when the feedback edge arrives first. Once both requests are raised, they stay high together for a fixed number of cycles before both clear. This overlap keeps the detector free of a dead zone near lock.

A second two-bit mode pin pair selects three things: whether the charge-pump drive is enabled, which detector polarity is used (the polarity swaps the up and down requests for oscillators whose frequency falls with tuning voltage), and what is driven on a monitor output (a constant level or one of the divided signals). Everything runs in one fast system clock that oversamples both incoming signals. Any change on the ratio or mode pins restarts both dividers and clears the detector.

Top module: `pfdc_top`

## Requirements
- R1: The reference path divides by exactly 2. With the mode pins at 01, the monitor output goes high on the 1st reference rising edge after a restart, low on the 2nd, high on the 3rd, and so on.
- R2: The feedback ratio is 8 << ratio pins (00 gives 8, 01 gives 16, 10 gives 32, 11 gives 64). After a restart, P feedback rising edges produce floor((P-1)/ratio)+1 rising edges of the divided feedback.
- R3: A divided output is high from the edge that starts its period through input edge ratio/2, and low for the remaining ratio/2 input edges.
- R4: Mode 00: charge-pump enable high, monitor constant 1, positive polarity (up follows the reference).
- R5: Mode 01: charge-pump enable low, both pump requests forced low, monitor shows the divided reference.
- R6: Mode 10: charge-pump enable high, monitor shows the divided feedback, positive polarity.
- R7: Mode 11: charge-pump enable high, monitor constant 0, negative polarity, so a reference-led request appears on the down output.
- R8: A divided-reference rise sets the up request and a divided-feedback rise sets the down request. A request stays set until the other one is also set.
- R9: Once both requests are set, they stay high together for exactly ABL_CYCLES system cycles (default 3) and then both clear. This also holds when both set in the same cycle.
- R10: A change on any ratio or mode pin clears both requests and restarts both dividers, so no partial count carries over.
- R11: Both inputs pass through two-flop synchronizers and only rising edges count, so a level held high for many cycles counts as one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples both inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Asynchronous reference signal |
| fb_in | input | 1 | Asynchronous feedback (oscillator) signal |
| ratio_sel | input | 2 | Feedback ratio select: 8 << ratio_sel |
| mode_sel | input | 2 | Pump enable, polarity and monitor select |
| pump_up | output | 1 | Pump-up request after polarity and enable |
| pump_dn | output | 1 | Pump-down request after polarity and enable |
| pump_oe | output | 1 | Charge-pump drive enable; low means high impedance |
| mon_out | output | 1 | Monitor output selected by the mode pins |

## Verification
Two situations can land in the same cycle. In the first, the divided reference and the divided feedback rise together. The bench provokes this by raising both inputs at one instant after a restart, and it passes only if both requests rise in the same cycle, overlap for exactly the configured count, and neither is ever seen high on its own. In the second, a pin change arrives while a single request is pending or a divider is mid-count. The bench changes the ratio pins in that state and expects the request to drop at once and the monitor to restart from the low half of a fresh period.

// File: rtl/pfdc_pkg.sv
// Shared types for the divider / phase-detector core.
// Assumes the mode encoding is fixed by the board-level pin strapping.
package pfdc_pkg;

    // Mode pin decode: pump state, polarity and monitor routing.
    typedef enum logic [1:0] {
        MD_RUN_HI  = 2'b00,  // pump on, monitor high, positive
        MD_TRI_REF = 2'b01,  // pump high-Z, monitor = divided reference
        MD_RUN_FB  = 2'b10,  // pump on, monitor = divided feedback
        MD_INV_LO  = 2'b11   // pump on, monitor low, negative polarity
    } mode_e;

endpackage

// File: rtl/pfdc_edge_sync.sv
// Two-flop synchronizer followed by a rising-edge detector.
// Assumes the input stays high and low for at least two clock periods each.
module pfdc_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    logic s1, s2, s3;

    // Resynchronize the input and keep one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= async_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise = s2 & ~s3;

    // R11: a detected edge lasts exactly one cycle.
    p_single_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/pfdc_divider.sv
// Edge-counting divider: counts input edges modulo `ratio` and gives a
// divided level (high for the first half of each period) and a one-cycle
// pulse on each rising edge of that level.
// Assumes ratio is even, at least 2, and below 2**CW + 1; clr restarts it.
module pfdc_divider #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          edge_in,
    input  logic [CW:0]   ratio,
    output logic          div_q,
    output logic          div_rise
);

    logic [CW:0] cnt;
    logic [CW:0] cnt_nxt;
    logic [CW:0] half;

    assign half    = ratio >> 1;
    assign cnt_nxt = (cnt == ratio - 1'b1) ? '0 : cnt + 1'b1;

    // Advance the modulo count on each input edge; restart on reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt      <= ratio - 1'b1;
            div_q    <= 1'b0;
            div_rise <= 1'b0;
        end else if (edge_in) begin
            cnt      <= cnt_nxt;
            div_q    <= (cnt_nxt < half);
            div_rise <= (cnt_nxt == '0);
        end else begin
            div_rise <= 1'b0;
        end
    end

    // R2: the count never reaches the active ratio.
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n || clr)
        cnt < ratio);

    // R3: every divided-edge pulse coincides with the divided level going high.
    p_rise_level_r3: assert property (@(posedge clk) disable iff (!rst_n || clr)
        div_rise |-> div_q);

endmodule

// File: rtl/pfdc_phase_det.sv
// Phase-frequency detector with an antibacklash overlap of ABL cycles.
// A reference pulse sets up_q, a feedback pulse sets dn_q; once both are
// set, they are held ABL cycles and then cleared together.
// Assumes the input pulses are single-cycle and clr restarts the state.
module pfdc_phase_det #(
    parameter int ABL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ref_rise,
    input  logic fb_rise,
    output logic up_q,
    output logic dn_q
);

    localparam int AW = (ABL > 1) ? $clog2(ABL) : 1;

    logic [AW-1:0] abl_cnt;
    logic          both;
    logic          abl_done;

    assign both     = up_q & dn_q;
    assign abl_done = both && (abl_cnt == AW'(ABL - 1));

    // Set on edges, hold the overlap, clear both when it has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            up_q    <= 1'b0;
            dn_q    <= 1'b0;
            abl_cnt <= '0;
        end else begin
            up_q    <= ref_rise | (up_q & ~abl_done);
            dn_q    <= fb_rise  | (dn_q & ~abl_done);
            abl_cnt <= (both && !abl_done) ? abl_cnt + 1'b1 : '0;
        end
    end

    // R8: a reference edge always leaves the up request set.
    p_set_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_rise && !clr) |=> up_q);

    // R8: a feedback edge always leaves the down request set.
    p_set_dn_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_rise && !clr) |=> dn_q);

    // R9: the overlap is not cut short.
    p_hold_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (both && !abl_done && !clr) |=> (up_q && dn_q));

    // R9: after the overlap both clear unless a fresh edge arrives.
    p_clear_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (abl_done && !clr && !ref_rise && !fb_rise) |=> (!up_q && !dn_q));

endmodule

// File: rtl/pfdc_top.sv
// Pin-configured divider and phase detector core. Divides the reference
// by REF_DIV and the feedback by FB_DIV_MIN << ratio_sel, compares the
// divided edges, and applies mode-pin polarity, pump enable and monitor
// routing. Assumes the pins are quasi-static; any change restarts the core.
module pfdc_top
    import pfdc_pkg::*;
#(
    parameter int REF_DIV    = 2,
    parameter int FB_DIV_MIN = 8,
    parameter int ABL_CYCLES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_in,
    input  logic       fb_in,
    input  logic [1:0] ratio_sel,
    input  logic [1:0] mode_sel,
    output logic       pump_up,
    output logic       pump_dn,
    output logic       pump_oe,
    output logic       mon_out
);

    localparam int FB_CW  = $clog2(FB_DIV_MIN << 3);
    localparam int REF_CW = (REF_DIV > 2) ? $clog2(REF_DIV) : 1;

    mode_e          mode;
    logic [3:0]     cfg_q;
    logic           cfg_chg;
    logic           ref_edge, fb_edge;
    logic           ref_q, ref_rise;
    logic           fb_q, fb_rise;
    logic           up_q, dn_q;
    logic           swap;
    logic [FB_CW:0] fb_ratio;

    assign mode     = mode_e'(mode_sel);
    assign cfg_chg  = ({ratio_sel, mode_sel} != cfg_q);
    assign fb_ratio = (FB_CW + 1)'(FB_DIV_MIN) << ratio_sel;

    // Remember the last pin setting so that a change can restart the core.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= {ratio_sel, mode_sel};
        else        cfg_q <= {ratio_sel, mode_sel};
    end

    pfdc_edge_sync u_ref_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ref_in),
        .rise     (ref_edge)
    );

    pfdc_edge_sync u_fb_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (fb_in),
        .rise     (fb_edge)
    );

    pfdc_divider #(.CW(REF_CW)) u_ref_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cfg_chg),
        .edge_in  (ref_edge),
        .ratio    ((REF_CW + 1)'(REF_DIV)),
        .div_q    (ref_q),
        .div_rise (ref_rise)
    );

    pfdc_divider #(.CW(FB_CW)) u_fb_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cfg_chg),
        .edge_in  (fb_edge),
        .ratio    (fb_ratio),
        .div_q    (fb_q),
        .div_rise (fb_rise)
    );

    pfdc_phase_det #(.ABL(ABL_CYCLES)) u_pfd (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cfg_chg),
        .ref_rise (ref_rise),
        .fb_rise  (fb_rise),
        .up_q     (up_q),
        .dn_q     (dn_q)
    );

    // Decode mode pins into pump enable, polarity and monitor source.
    always_comb begin
        pump_oe = (mode != MD_TRI_REF);
        swap    = (mode == MD_INV_LO);
        unique case (mode)
            MD_RUN_HI:  mon_out = 1'b1;
            MD_TRI_REF: mon_out = ref_q;
            MD_RUN_FB:  mon_out = fb_q;
            default:    mon_out = 1'b0;
        endcase
        pump_up = pump_oe & (swap ? dn_q : up_q);
        pump_dn = pump_oe & (swap ? up_q : dn_q);
    end

    // R5: with the pump in high impedance no request is driven.
    p_tristate_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pump_oe |-> (!pump_up && !pump_dn));

    // R10: a pin change leaves the detector empty on the next cycle.
    p_cfg_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (!up_q && !dn_q));

    // R7: in negative polarity a pending reference request drives the down pin.
    p_polarity_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_INV_LO && up_q && !dn_q) |-> (pump_dn && !pump_up));

endmodule

// File: tb/test_pfdc_top.sv
`timescale 1ns/1ps
module test_pfdc_top;

    localparam int K = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       fb_in = 1'b0;
    logic [1:0] ratio_sel = 2'b00;
    logic [1:0] mode_sel = 2'b00;
    logic       pump_up, pump_dn, pump_oe, mon_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int mon_rises = 0;
    int ovl_cyc   = 0;
    int up_only   = 0;
    int dn_only   = 0;
    logic mon_prev = 1'b0;

    always #2 clk = ~clk;

    pfdc_top #(.REF_DIV(2), .FB_DIV_MIN(8), .ABL_CYCLES(K)) i_pfdc_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_in    (ref_in),
        .fb_in     (fb_in),
        .ratio_sel (ratio_sel),
        .mode_sel  (mode_sel),
        .pump_up   (pump_up),
        .pump_dn   (pump_dn),
        .pump_oe   (pump_oe),
        .mon_out   (mon_out)
    );

    // Observation counters sampled mid-cycle.
    always @(negedge clk) begin
        if (mon_out && !mon_prev) mon_rises = mon_rises + 1;
        mon_prev = mon_out;
        if (pump_up && pump_dn)  ovl_cyc = ovl_cyc + 1;
        if (pump_up && !pump_dn) up_only = up_only + 1;
        if (!pump_up && pump_dn) dn_only = dn_only + 1;
    end

    function automatic int fb_rises_expected(int p, int ratio);
        return (p - 1) / ratio + 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ref();
        ref_in = 1'b1; tick(6); ref_in = 1'b0; tick(6);
    endtask

    task automatic pulse_fb();
        fb_in = 1'b1; tick(6); fb_in = 1'b0; tick(6);
    endtask

    task automatic pulse_both();
        ref_in = 1'b1; fb_in = 1'b1; tick(6);
        ref_in = 1'b0; fb_in = 1'b0; tick(6);
    endtask

    task automatic set_cfg(input logic [1:0] n, input logic [1:0] m);
        ratio_sel = n; mode_sel = m; tick(4);
    endtask

    // Force a restart even if the requested setting equals the current one.
    task automatic fresh(input logic [1:0] n, input logic [1:0] m);
        set_cfg(n ^ 2'b01, m);
        set_cfg(n, m);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int base, b_ovl, b_up, b_dn, p, n;
        void'($urandom(32'h00C0FFEE));
        tick(4);
        rst_n = 1'b1;
        tick(4);

        // Reset state, mode 00 (R4)
        chk(pump_up == 1'b0 && pump_dn == 1'b0, "R4 reset requests", {pump_up, pump_dn}, 0);
        chk(pump_oe == 1'b1, "R4 pump enable", pump_oe, 1);
        chk(mon_out == 1'b1, "R4 monitor high", mon_out, 1);

        // R1: reference divided by two, seen on monitor in mode 01
        fresh(2'b00, 2'b01);
        chk(mon_out == 1'b0, "R1 after restart", mon_out, 0);
        pulse_ref();
        chk(mon_out == 1'b1, "R1 first edge", mon_out, 1);
        pulse_ref();
        chk(mon_out == 1'b0, "R1 second edge", mon_out, 0);
        pulse_ref();
        chk(mon_out == 1'b1, "R1 third edge", mon_out, 1);
        // R5: tri-state forces requests low even with a pending reference request
        chk(pump_oe == 1'b0, "R5 pump disabled", pump_oe, 0);
        chk(pump_up == 1'b0 && pump_dn == 1'b0, "R5 requests low", {pump_up, pump_dn}, 0);

        // R3: duty of the divided feedback at ratio 16 (R6 monitor routing)
        fresh(2'b01, 2'b10);
        chk(pump_oe == 1'b1, "R6 pump enabled", pump_oe, 1);
        for (int i = 1; i <= 17; i++) begin
            pulse_fb();
            if (i == 1 || i == 8)
                chk(mon_out == 1'b1, "R3 high half", mon_out, 1);
            if (i == 9 || i == 16)
                chk(mon_out == 1'b0, "R3 low half", mon_out, 0);
            if (i == 17)
                chk(mon_out == 1'b1, "R3 next period", mon_out, 1);
        end

        // R11: a long high level counts as one edge
        fresh(2'b00, 2'b10);
        base = mon_rises;
        fb_in = 1'b1; tick(60); fb_in = 1'b0; tick(6);
        pulse_fb();
        chk(mon_rises - base == 1, "R11 held level one edge", mon_rises - base, 1);
        chk(mon_out == 1'b1, "R11 count is two", mon_out, 1);

        // R2: random ratios and edge counts
        for (int it = 0; it < 8; it++) begin
            n = $urandom_range(3, 0);
            p = $urandom_range(3 * (8 << n), 1);
            fresh(2'(n), 2'b10);
            base = mon_rises;
            for (int j = 0; j < p; j++) pulse_fb();
            chk(mon_rises - base == fb_rises_expected(p, 8 << n), "R2 divided feedback edges",
                mon_rises - base, fb_rises_expected(p, 8 << n));
        end
        // R2: directed boundary, ratio 64 with exactly 64 and 65 edges
        fresh(2'b11, 2'b10);
        base = mon_rises;
        for (int j = 0; j < 64; j++) pulse_fb();
        chk(mon_rises - base == 1, "R2 ratio 64 full period", mon_rises - base, 1);
        pulse_fb();
        chk(mon_rises - base == 2, "R2 ratio 64 wrap", mon_rises - base, 2);

        // R8 / R9: reference first, then feedback, positive polarity
        fresh(2'b00, 2'b00);
        pulse_ref();
        chk(pump_up == 1'b1 && pump_dn == 1'b0, "R8 up pending", {pump_up, pump_dn}, 2);
        b_ovl = ovl_cyc;
        pulse_fb();
        chk(ovl_cyc - b_ovl == K, "R9 overlap width", ovl_cyc - b_ovl, K);
        chk(pump_up == 1'b0 && pump_dn == 1'b0, "R9 both cleared", {pump_up, pump_dn}, 0);
        pulse_ref();
        chk(pump_up == 1'b0, "R1 second reference edge no request", pump_up, 0);

        // R8: feedback first sets down
        fresh(2'b00, 2'b00);
        pulse_fb();
        chk(pump_up == 1'b0 && pump_dn == 1'b1, "R8 down pending", {pump_up, pump_dn}, 1);

        // R7: negative polarity swaps outputs, monitor low
        fresh(2'b00, 2'b11);
        chk(mon_out == 1'b0, "R7 monitor low", mon_out, 0);
        pulse_ref();
        chk(pump_up == 1'b0 && pump_dn == 1'b1, "R7 swapped request", {pump_up, pump_dn}, 1);
        b_ovl = ovl_cyc;
        pulse_fb();
        chk(ovl_cyc - b_ovl == K, "R9 overlap in negative mode", ovl_cyc - b_ovl, K);

        // R9: simultaneous divided edges
        fresh(2'b00, 2'b00);
        b_ovl = ovl_cyc; b_up = up_only; b_dn = dn_only;
        pulse_both();
        chk(ovl_cyc - b_ovl == K, "R9 simultaneous overlap", ovl_cyc - b_ovl, K);
        chk(up_only - b_up == 0 && dn_only - b_dn == 0, "R9 simultaneous no lone request",
            (up_only - b_up) + (dn_only - b_dn), 0);

        // R10: pin change clears a pending request
        fresh(2'b00, 2'b00);
        pulse_ref();
        ratio_sel = 2'b10;
        tick(2);
        chk(pump_up == 1'b0 && pump_dn == 1'b0, "R10 request cleared", {pump_up, pump_dn}, 0);

        // R10: pin change restarts a part-way divider
        fresh(2'b00, 2'b10);
        pulse_fb(); pulse_fb(); pulse_fb();
        chk(mon_out == 1'b1, "R10 before change", mon_out, 1);
        ratio_sel = 2'b01;
        tick(2);
        chk(mon_out == 1'b0, "R10 divider restarted", mon_out, 0);
        pulse_fb();
        chk(mon_out == 1'b1, "R10 fresh period", mon_out, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule